// File: doc/BRIEF.md
# I2C Master Holding-Register, Lock and Status Unit

This block sits between a register bus and the byte shifter of an I2C master. It keeps one transmit holding byte and one receive holding byte. It drives the transmit and receive DMA request lines and keeps the status word. From the status word and a software mask it raises one interrupt line. The shifter is modelled as a handshake. It pulls a byte with a pop strobe, pushes received bytes, and signals when the slave did not acknowledge and when STOP has gone out.

When the slave does not acknowledge, the transmit path locks. Transmit DMA requests stop, and the shifter is refused any byte. A byte that software or DMA writes later stays in the holding register and is not sent. The lock is released only by an explicit control command, and the stranded byte can be flushed by another. Transmission-complete is a live level and is never cleared by reading. NACK, overrun and underrun are sticky and are cleared when the status word is read.

Register addresses on the 3-bit bus: control 0, status 1, interrupt enable 2, interrupt disable 3, mask 4, receive data 5, transmit data 6.

Top module: `i2c_tls_top`

## Requirements
- R1: After reset the status word reads 0x0000_0005 (bit 0 transmission-complete and bit 2 transmit-ready set), the mask reads 0 and irq is low.
- R2: Transmission-complete (status bit 0) goes low in the cycle after a transmit-data write, or after a control write with bits 0 (start) and 1 (read) both set. It returns high after an engine STOP strobe while the transmit holding register is empty.
- R3: An engine NACK strobe sets NACK (bit 8), LOCK (bit 23) and transmission-complete (bit 0) from the next cycle.
- R4: While LOCK is set, dma_tx_req is low and an engine pop is neither granted nor counted as underrun. A byte written then stays held (bit 2 low), and transmission-complete drops.
- R5: LOCK clears only on a control write with bit 26 set. Control bit 24 empties the transmit holding register, and also sets transmission-complete when LOCK is set. Control bit 25 empties the receive holding register.
- R6: An engine push sets receive-ready (bit 1) and dma_rx_req. A read at address 5 returns the byte in the low bits and clears receive-ready.
- R7: A push while receive-ready is high, without a receive-data read in the same cycle, sets overrun (bit 6), and the new byte replaces the old one.
- R8: An unlocked pop while the transmit holding register is empty sets underrun (bit 7).
- R9: NACK, overrun and underrun clear on a status read, which still returns their old values. A setting event in the same cycle wins.
- R10: A write to address 2 sets and a write to address 3 clears mask bits. Only bits 0, 1, 2 and 8 can be set, and the mask reads back at address 4.
- R11: irq is high exactly when some status bit and its mask bit are both set.
- R12: An unlocked pop with a full transmit holding register is granted in the same cycle with the held byte on eng_tx_byte. The register then empties, raising bit 2 and dma_tx_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| eng_tx_pop | input | 1 | Shifter asks for the next transmit byte |
| eng_tx_grant | output | 1 | Pop accepted, byte valid |
| eng_tx_byte | output | DW | Byte handed to the shifter |
| eng_rx_push | input | 1 | Shifter delivers a received byte |
| eng_rx_byte | input | DW | Received byte |
| eng_nack | input | 1 | Slave did not acknowledge |
| eng_stop | input | 1 | STOP condition has been sent |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default byte width of 8. This places received bytes directly in the low byte of the read word and leaves the upper 24 bits for the zero-extension check. The control, enable and disable words stay at their full 32 bits. This lets random writes hit the lock-clear, flush and start bits, and lets the mask filter be tried against every bit position. Directed phases reach the lock-then-write case, overrun and underrun, and status reads that coincide with new events. A random phase then mixes all strobes against the reference model.

// File: rtl/i2c_tls_pkg.sv
package i2c_tls_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    // status bit positions
    localparam int ST_TXCOMP = 0;
    localparam int ST_RXRDY  = 1;
    localparam int ST_TXRDY  = 2;
    localparam int ST_OVR    = 6;
    localparam int ST_UNR    = 7;
    localparam int ST_NACK   = 8;
    localparam int ST_LOCK   = 23;

    // control bit positions
    localparam int CT_START   = 0;
    localparam int CT_RDIR    = 1;
    localparam int CT_THRCLR  = 24;
    localparam int CT_RHRCLR  = 25;
    localparam int CT_LOCKCLR = 26;

    localparam logic [REG_W-1:0] MASKABLE =
        (REG_W'(1) << ST_TXCOMP) | (REG_W'(1) << ST_RXRDY) |
        (REG_W'(1) << ST_TXRDY)  | (REG_W'(1) << ST_NACK);

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_IEN  = 3'd2,
        RA_IDIS = 3'd3,
        RA_MASK = 3'd4,
        RA_RXD  = 3'd5,
        RA_TXD  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/i2c_tls_hold.sv
module i2c_tls_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_wr,
    input  logic [DW-1:0] thr_wdata,
    input  logic          thr_clr,
    input  logic          pop_ok,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    input  logic          rhr_rd,
    input  logic          rhr_clr,
    output logic          thr_full,
    output logic [DW-1:0] thr_data,
    output logic          rhr_full,
    output logic [DW-1:0] rhr_data
);
    typedef struct packed {
        logic [DW-1:0] thr;
        logic          thr_full;
        logic [DW-1:0] rhr;
        logic          rhr_full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        // transmit side: pop, then flush, then a new write
        if (pop_ok)  hold_d.thr_full = 1'b0;
        if (thr_clr) hold_d.thr_full = 1'b0;
        if (thr_wr) begin
            hold_d.thr_full = 1'b1;
            hold_d.thr      = thr_wdata;
        end
        // receive side: read, then flush, then a new byte
        if (rhr_rd)  hold_d.rhr_full = 1'b0;
        if (rhr_clr) hold_d.rhr_full = 1'b0;
        if (rx_push) begin
            hold_d.rhr_full = 1'b1;
            hold_d.rhr      = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign thr_full = hold_q.thr_full;
    assign thr_data = hold_q.thr;
    assign rhr_full = hold_q.rhr_full;
    assign rhr_data = hold_q.rhr;

    a_r12_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !thr_wr) |=> !thr_full);
    a_r6_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> (rhr_full && rhr_data == $past(rx_byte)));
endmodule

// File: rtl/i2c_tls_flags.sv
module i2c_tls_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic start_rd,
    input  logic stop_ev,
    input  logic nack_ev,
    input  logic thr_full,
    input  logic rhr_full,
    input  logic tx_pop,
    input  logic rx_push,
    input  logic rhr_rd,
    input  logic stat_rd,
    input  logic lock_clr,
    input  logic thr_clr,
    output logic txcomp,
    output logic ovr,
    output logic unr,
    output logic nack,
    output logic lock
);
    typedef struct packed {
        logic txcomp;
        logic ovr;
        logic unr;
        logic nack;
        logic lock;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   ovr_ev, unr_ev;

    always_comb begin
        ovr_ev = rx_push && rhr_full && !rhr_rd;
        unr_ev = tx_pop && !fl_q.lock && !thr_full;

        fl_d      = fl_q;
        fl_d.nack = (fl_q.nack && !stat_rd) || nack_ev;
        fl_d.ovr  = (fl_q.ovr  && !stat_rd) || ovr_ev;
        fl_d.unr  = (fl_q.unr  && !stat_rd) || unr_ev;
        fl_d.lock = (fl_q.lock && !lock_clr) || nack_ev;

        if (nack_ev)                     fl_d.txcomp = 1'b1;
        else if (thr_wr || start_rd)     fl_d.txcomp = 1'b0;
        else if (thr_clr && fl_q.lock)   fl_d.txcomp = 1'b1;
        else if (stop_ev && !thr_full)   fl_d.txcomp = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q        <= '0;
            fl_q.txcomp <= 1'b1;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign txcomp = fl_q.txcomp;
    assign ovr    = fl_q.ovr;
    assign unr    = fl_q.unr;
    assign nack   = fl_q.nack;
    assign lock   = fl_q.lock;

    a_r2_txcomp_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !nack_ev) |=> !txcomp);
    a_r3_nack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        nack_ev |=> (nack && lock && txcomp));
    a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !lock_clr) |=> lock);
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rhr_full && !rhr_rd) |=> ovr);
    a_r4_no_unr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !unr && !stat_rd && !lock_clr && !nack_ev) |=> (lock && !unr));
endmodule

// File: rtl/i2c_tls_irq.sv
module i2c_tls_irq
    import i2c_tls_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] status,
    output logic [REG_W-1:0] mask,
    output logic             irq
);
    logic [REG_W-1:0] mask_d, mask_q;
    logic [REG_W-1:0] hit;

    always_comb begin
        mask_d = mask_q;
        if (ien_wr)  mask_d = mask_d | (wdata & MASKABLE);
        if (idis_wr) mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_hit
        assign hit[b] = status[b] & mask_q[b];
    end

    assign mask = mask_q;
    assign irq  = |hit;

    a_r10_ien: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> ((mask & ($past(wdata) & MASKABLE)) == ($past(wdata) & MASKABLE)));
    a_r10_idis: assert property (@(posedge clk) disable iff (!rst_n)
        idis_wr |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/i2c_tls_top.sv
module i2c_tls_top
    import i2c_tls_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              eng_tx_pop,
    output logic              eng_tx_grant,
    output logic [DW-1:0]     eng_tx_byte,
    input  logic              eng_rx_push,
    input  logic [DW-1:0]     eng_rx_byte,
    input  logic              eng_nack,
    input  logic              eng_stop,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic              irq
);
    localparam int PAD_W = REG_W - DW;

    logic ctrl_wr, thr_wr, ien_wr, idis_wr, stat_rd, rhr_rd;
    logic start_rd, thr_clr, rhr_clr, lock_clr, pop_ok;
    logic thr_full, rhr_full;
    logic [DW-1:0] thr_data, rhr_data;
    logic txcomp, ovr, unr, nack, lock;
    logic [REG_W-1:0] status, mask;

    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == RA_CTRL);
        thr_wr   = bus_wr && (bus_addr == RA_TXD);
        ien_wr   = bus_wr && (bus_addr == RA_IEN);
        idis_wr  = bus_wr && (bus_addr == RA_IDIS);
        stat_rd  = bus_rd && (bus_addr == RA_STAT);
        rhr_rd   = bus_rd && (bus_addr == RA_RXD);
        start_rd = ctrl_wr && bus_wdata[CT_START] && bus_wdata[CT_RDIR];
        thr_clr  = ctrl_wr && bus_wdata[CT_THRCLR];
        rhr_clr  = ctrl_wr && bus_wdata[CT_RHRCLR];
        lock_clr = ctrl_wr && bus_wdata[CT_LOCKCLR];
        pop_ok   = eng_tx_pop && thr_full && !lock;
    end

    i2c_tls_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (thr_wr),
        .thr_wdata (bus_wdata[DW-1:0]),
        .thr_clr   (thr_clr),
        .pop_ok    (pop_ok),
        .rx_push   (eng_rx_push),
        .rx_byte   (eng_rx_byte),
        .rhr_rd    (rhr_rd),
        .rhr_clr   (rhr_clr),
        .thr_full  (thr_full),
        .thr_data  (thr_data),
        .rhr_full  (rhr_full),
        .rhr_data  (rhr_data)
    );

    i2c_tls_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_wr   (thr_wr),
        .start_rd (start_rd),
        .stop_ev  (eng_stop),
        .nack_ev  (eng_nack),
        .thr_full (thr_full),
        .rhr_full (rhr_full),
        .tx_pop   (eng_tx_pop),
        .rx_push  (eng_rx_push),
        .rhr_rd   (rhr_rd),
        .stat_rd  (stat_rd),
        .lock_clr (lock_clr),
        .thr_clr  (thr_clr),
        .txcomp   (txcomp),
        .ovr      (ovr),
        .unr      (unr),
        .nack     (nack),
        .lock     (lock)
    );

    always_comb begin
        status            = '0;
        status[ST_TXCOMP] = txcomp;
        status[ST_RXRDY]  = rhr_full;
        status[ST_TXRDY]  = !thr_full;
        status[ST_OVR]    = ovr;
        status[ST_UNR]    = unr;
        status[ST_NACK]   = nack;
        status[ST_LOCK]   = lock;
    end

    i2c_tls_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (ien_wr),
        .idis_wr (idis_wr),
        .wdata   (bus_wdata),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                RA_STAT: bus_rdata = status;
                RA_MASK: bus_rdata = mask;
                RA_RXD:  bus_rdata = {{PAD_W{1'b0}}, rhr_data};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign eng_tx_grant = pop_ok;
    assign eng_tx_byte  = thr_data;
    assign dma_tx_req   = !thr_full && !lock;
    assign dma_rx_req   = rhr_full;

    a_r4_no_dma_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack |=> !dma_tx_req);
    a_r4_no_grant_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        eng_nack |=> !eng_tx_grant);
endmodule

// File: tb/i2c_tls_top_test.sv
`timescale 1ns/1ps
module i2c_tls_top_test;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_nack = 0, eng_stop = 0;
    logic [DW-1:0] eng_rx_byte = 0;
    logic        eng_tx_grant, dma_tx_req, dma_rx_req, irq;
    logic [DW-1:0] eng_tx_byte;

    always #2.5 clk = ~clk;

    i2c_tls_top #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_grant(eng_tx_grant),
        .eng_tx_byte(eng_tx_byte), .eng_rx_push(eng_rx_push),
        .eng_rx_byte(eng_rx_byte), .eng_nack(eng_nack), .eng_stop(eng_stop),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
    );

    int errors = 0, checks = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_thr = 0, m_rhr = 0;
    bit m_thr_full = 0, m_rhr_full = 0;
    bit m_txc = 1, m_ovr = 0, m_unr = 0, m_nack = 0, m_lock = 0;
    int unsigned m_mask = 0;

    function automatic int unsigned m_status();
        int unsigned s = 0;
        if (m_txc)       s += 32'h1;
        if (m_rhr_full)  s += 32'h2;
        if (!m_thr_full) s += 32'h4;
        if (m_ovr)       s += 32'h40;
        if (m_unr)       s += 32'h80;
        if (m_nack)      s += 32'h100;
        if (m_lock)      s += 32'h80_0000;
        return s;
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_now();
        int unsigned exp_rd = 0;
        bit grant = eng_tx_pop && m_thr_full && !m_lock;
        if (bus_rd) begin
            if (bus_addr == 3'd1) exp_rd = m_status();
            else if (bus_addr == 3'd4) exp_rd = m_mask;
            else if (bus_addr == 3'd5) exp_rd = m_rhr;
        end
        check(tag, bus_rdata, exp_rd);
        check("R11", irq, (m_status() & m_mask) != 0);
        check("R4", dma_tx_req, !m_thr_full && !m_lock);
        check("R6", dma_rx_req, m_rhr_full);
        check("R12", eng_tx_grant, grant);
        if (grant) check("R12", eng_tx_byte, m_thr);
    endtask

    task automatic model_update();
        bit ctrl = bus_wr && bus_addr == 3'd0;
        bit thr_wr = bus_wr && bus_addr == 3'd6;
        bit stat_rd = bus_rd && bus_addr == 3'd1;
        bit rhr_rd = bus_rd && bus_addr == 3'd5;
        bit thr_clr = ctrl && bus_wdata[24];
        bit rhr_clr = ctrl && bus_wdata[25];
        bit lk_clr = ctrl && bus_wdata[26];
        bit st_rd = ctrl && bus_wdata[0] && bus_wdata[1];
        bit pop_ok = eng_tx_pop && m_thr_full && !m_lock;
        bit ovr_ev = eng_rx_push && m_rhr_full && !rhr_rd;
        bit unr_ev = eng_tx_pop && !m_lock && !m_thr_full;
        bit old_full = m_thr_full, old_lock = m_lock;
        if (stat_rd) begin m_nack = 0; m_ovr = 0; m_unr = 0; end
        if (eng_nack) m_nack = 1;
        if (ovr_ev) m_ovr = 1;
        if (unr_ev) m_unr = 1;
        if (eng_nack) m_txc = 1;
        else if (thr_wr || st_rd) m_txc = 0;
        else if (thr_clr && old_lock) m_txc = 1;
        else if (eng_stop && !old_full) m_txc = 1;
        if (lk_clr) m_lock = 0;
        if (eng_nack) m_lock = 1;
        if (pop_ok || thr_clr) m_thr_full = 0;
        if (thr_wr) begin m_thr_full = 1; m_thr = bus_wdata[7:0]; end
        if (rhr_rd || rhr_clr) m_rhr_full = 0;
        if (eng_rx_push) begin m_rhr_full = 1; m_rhr = eng_rx_byte; end
        if (bus_wr && bus_addr == 3'd2) m_mask |= bus_wdata & 32'h107;
        if (bus_wr && bus_addr == 3'd3) m_mask &= ~bus_wdata;
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_rx_byte = 0;
        eng_nack = 0; eng_stop = 0;
    endtask

    task automatic step();
        #1;
        compare_now();
        model_update();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; step();
    endtask
    task automatic rd(input logic [2:0] a);
        bus_rd = 1; bus_addr = a; step();
    endtask
    task automatic pop();  eng_tx_pop = 1; step(); endtask
    task automatic stopx(); eng_stop = 1; step(); endtask
    task automatic nackx(); eng_nack = 1; step(); endtask
    task automatic push(input logic [7:0] b);
        eng_rx_push = 1; eng_rx_byte = b; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1"; rd(3'd1); rd(3'd4);
        check("R1", irq, 0);
        // R10 mask
        tag = "R10"; wr(3'd2, 32'hFFFF_FFFF); rd(3'd4);
        wr(3'd3, 32'h4); rd(3'd4);
        // R12, R2 transmit path
        tag = "R12"; wr(3'd6, 32'hA5); rd(3'd1); pop(); rd(3'd1);
        tag = "R2"; stopx(); rd(3'd1);
        wr(3'd0, 32'h3); rd(3'd1); stopx(); rd(3'd1);
        // R6 receive path
        tag = "R6"; push(8'h3C); rd(3'd1); rd(3'd5); rd(3'd1);
        // R7 overrun
        tag = "R7"; push(8'h11); push(8'h22); rd(3'd1); rd(3'd5);
        // R8 underrun and R9 clear-on-read
        tag = "R8"; pop(); rd(3'd1);
        tag = "R9"; rd(3'd1);
        eng_tx_pop = 1; bus_rd = 1; bus_addr = 3'd1; step(); rd(3'd1); rd(3'd1);
        // R3 nack lock
        tag = "R3"; wr(3'd6, 32'h5A); nackx(); rd(3'd1);
        // R4 locked behaviour
        tag = "R4"; pop(); wr(3'd6, 32'h77); rd(3'd1); pop(); rd(3'd1);
        // R5 recovery commands
        tag = "R5"; push(8'h99); wr(3'd0, 32'h0200_0000); rd(3'd1);
        wr(3'd0, 32'h0100_0000); rd(3'd1);
        wr(3'd0, 32'h0000_0000); rd(3'd1);
        wr(3'd0, 32'h0400_0000); rd(3'd1);
        // R11 random mix
        tag = "R11";
        wr(3'd2, 32'h107);
        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom;
            if (r[0]) begin
                bus_wr = 1;
                bus_addr = 3'($urandom_range(0, 6));
                bus_wdata = $urandom;
                if (bus_addr == 3'd0) bus_wdata = bus_wdata & 32'h0700_0003;
            end else if (r[1]) begin
                bus_rd = 1;
                bus_addr = 3'($urandom_range(0, 7));
            end
            eng_tx_pop  = (r[5:3] == 0);
            eng_rx_push = (r[8:6] == 0);
            eng_rx_byte = r[23:16];
            eng_nack    = (r[13:9] == 0);
            eng_stop    = (r[15:14] == 0);
            step();
        end
        finish_run();
    end
endmodule